// File: doc/BRIEF.md
# Memory Write Integrity CRC Accumulator

This block keeps a running 32-bit CRC over the words a host writes into two memories, an instruction store and a data store. It snoops the host-side request strobes, byte masks, word indices and write data of both memories and, for every write that qualifies, assembles a 48-bit record that is folded into a CRC register within one cycle. A qualifying write is a full-word host write (all four byte-mask bits set) made while the core touches neither memory. Partial writes, misaligned writes and writes that collide with core traffic are left out of the sum.

The host reads the accumulated value from `crc_o` and may overwrite it through `crc_wr_i`/`crc_wdata_i`. The usual use is to clear it to zero before loading a program and its data. After the load, the host compares the register against a value computed off-chip. The register holds the raw running remainder: no inversion is applied on entry or exit.

The incoming bus word is fixed at 32 bits, and a parameter check stops elaboration for any other width. The instruction store may carry extra bits beyond the low word, and these are not folded in.

Top module: `memwr_crc_acc`

## Requirements
- R1: The record for a write is 48 bits: bit 47 is the memory select (1 = instruction store, 0 = data store), bits 46:32 hold the 10-bit word index zero-extended to 15 bits, and bits 31:0 hold the written word.
- R2: A fold uses the reflected CRC-32 polynomial 0xEDB88320 with no input or output inversion. It consumes the record one bit at a time from bit 0 up to bit 47 (six bytes, least-significant first). The new value is visible on `crc_o` after the next rising clock edge.
- R3: A write advances the CRC only if its 4-bit byte mask is 4'hf. Any other mask leaves `crc_o` unchanged.
- R4: When either core-access input is high in a cycle, no host write in that cycle changes `crc_o`.
- R5: If the instruction-store request is high, the record takes memory select 1 together with that store's index and the low 32 bits of its write data. Otherwise it takes select 0 with the data store's index and the low 32 bits of its data. The write qualifies if either active request carries a full mask, so a partial-mask instruction write together with a full-mask data write folds the instruction-store record.
- R6: When `crc_wr_i` is high, `crc_o` equals `crc_wdata_i` after the next rising edge.
- R7: A host register write in the same cycle as a qualifying memory write wins, and the memory write is not folded.
- R8: `rst_ni` low at a rising edge sets `crc_o` to 32'h00000000 (synchronous, active low), overriding every other input.
- R9: With no request and no register write, `crc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| imem_host_req_i | input | 1 | Host write request to the instruction store |
| imem_host_mask_i | input | 4 | Byte mask of the instruction-store write |
| imem_host_idx_i | input | 10 | Word index of the instruction-store write |
| imem_host_wdata_i | input | 39 | Instruction-store write data (low 32 bits used) |
| dmem_host_req_i | input | 1 | Host write request to the data store |
| dmem_host_mask_i | input | 4 | Byte mask of the data-store write |
| dmem_host_idx_i | input | 10 | Word index of the data-store write |
| dmem_host_wdata_i | input | 32 | Data-store write data |
| core_imem_acc_i | input | 1 | Core is accessing the instruction store this cycle |
| core_dmem_acc_i | input | 1 | Core is accessing the data store this cycle |
| crc_wr_i | input | 1 | Host write strobe for the CRC register |
| crc_wdata_i | input | 32 | Value loaded by a host register write |
| crc_o | output | 32 | Current CRC value |

## Verification
The cases hardest to reach from the ports are those where several sources contend in one cycle. These include a register write together with a full-mask memory write, both memory requests at once with only the data-store mask full, and a full-mask host write during core traffic to the other store. The stimulus table holds rows that drive these combinations together in a single cycle. An independent bit-serial model then predicts the outcome, so a wrong priority, a wrong source choice or a missed gate shows up as a value mismatch. A reset applied while a register write and a memory write are both pending checks that reset overrides everything.

// File: rtl/memwr_crc_pkg.sv
package memwr_crc_pkg;

   // Default geometry of the folded record
   localparam int unsigned DefIdxW    = 10;
   localparam int unsigned DefRecIdxW = 15;
   localparam int unsigned DefWordW   = 32;
   localparam int unsigned DefMaskW   = 4;
   localparam int unsigned DefCrcW    = 32;

   // Reflected form of the CRC-32 generator 0x04C11DB7
   localparam logic [31:0] Crc32ReflPoly = 32'hEDB88320;

   // Which store supplies the record
   typedef enum logic {
      SRC_DMEM = 1'b0,
      SRC_IMEM = 1'b1
   } rec_src_e;

endpackage

// File: rtl/memwr_crc_byte.sv
// One byte of a reflected CRC update, unrolled over its eight bits.
module memwr_crc_byte #(
   parameter int unsigned         CRC_W = 32,
   parameter logic [CRC_W-1:0]    POLY  = 32'hEDB88320
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic [7:0]       byte_i,
   output logic [CRC_W-1:0] crc_o
);

   localparam int unsigned NBits = 8;

   if (CRC_W < NBits) begin : g_bad_crc_w
      $error("memwr_crc_byte: CRC_W must be at least 8");
   end

   logic [CRC_W-1:0] step [NBits+1];

   assign step[0] = crc_i ^ {{(CRC_W-NBits){1'b0}}, byte_i};

   for (genvar b = 0; b < NBits; b++) begin : g_bit
      assign step[b+1] = step[b][0] ? ((step[b] >> 1) ^ POLY) : (step[b] >> 1);
   end

   assign crc_o = step[NBits];

endmodule

// File: rtl/memwr_crc_fold.sv
// Folds a whole record into the CRC, least-significant byte first.
module memwr_crc_fold #(
   parameter int unsigned      CRC_W = 32,
   parameter int unsigned      REC_W = 48,
   parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic [REC_W-1:0] rec_i,
   output logic [CRC_W-1:0] crc_o
);

   localparam int unsigned NBytes = REC_W / 8;

   if ((REC_W % 8) != 0 || REC_W == 0) begin : g_bad_rec_w
      $error("memwr_crc_fold: REC_W must be a non-zero multiple of 8");
   end

   logic [CRC_W-1:0] chain [NBytes+1];

   assign chain[0] = crc_i;

   for (genvar k = 0; k < NBytes; k++) begin : g_byte
      memwr_crc_byte #(
         .CRC_W (CRC_W),
         .POLY  (POLY)
      ) u_byte (
         .crc_i  (chain[k]),
         .byte_i (rec_i[8*k +: 8]),
         .crc_o  (chain[k+1])
      );
   end

   assign crc_o = chain[NBytes];

endmodule

// File: rtl/memwr_crc_qual.sv
// Decides whether a host write counts and builds its record.
module memwr_crc_qual
   import memwr_crc_pkg::*;
#(
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned REC_IDX_W = 15,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned MASK_W    = 4,
   parameter int unsigned IMEM_WD_W = 39,
   parameter int unsigned DMEM_WD_W = 32,
   localparam int unsigned REC_W    = 1 + REC_IDX_W + WORD_W
) (
   input  logic                 imem_req_i,
   input  logic [MASK_W-1:0]    imem_mask_i,
   input  logic [IDX_W-1:0]     imem_idx_i,
   input  logic [IMEM_WD_W-1:0] imem_wdata_i,
   input  logic                 dmem_req_i,
   input  logic [MASK_W-1:0]    dmem_mask_i,
   input  logic [IDX_W-1:0]     dmem_idx_i,
   input  logic [DMEM_WD_W-1:0] dmem_wdata_i,
   input  logic                 core_imem_i,
   input  logic                 core_dmem_i,
   output logic                 fold_en_o,
   output logic [REC_W-1:0]     rec_o
);

   localparam logic [MASK_W-1:0] FullMask = {MASK_W{1'b1}};

   if (IDX_W > REC_IDX_W) begin : g_bad_idx
      $error("memwr_crc_qual: IDX_W must not exceed REC_IDX_W");
   end
   if (IMEM_WD_W < WORD_W || DMEM_WD_W < WORD_W) begin : g_bad_wd
      $error("memwr_crc_qual: write data narrower than a word");
   end

   // Bits above the folded word are intentionally not part of the record
   if (IMEM_WD_W > WORD_W) begin : g_imem_hi
      logic unused_imem_hi;
      assign unused_imem_hi = ^imem_wdata_i[IMEM_WD_W-1:WORD_W];
   end
   if (DMEM_WD_W > WORD_W) begin : g_dmem_hi
      logic unused_dmem_hi;
      assign unused_dmem_hi = ^dmem_wdata_i[DMEM_WD_W-1:WORD_W];
   end

   logic                 core_busy;
   logic                 imem_full;
   logic                 dmem_full;
   rec_src_e             src;
   logic [IDX_W-1:0]     idx_sel;
   logic [WORD_W-1:0]    word_sel;
   logic [REC_IDX_W-1:0] idx_ext;

   assign core_busy = core_imem_i | core_dmem_i;
   assign imem_full = imem_req_i & (imem_mask_i == FullMask);
   assign dmem_full = dmem_req_i & (dmem_mask_i == FullMask);
   assign fold_en_o = ~core_busy & (imem_full | dmem_full);

   always_comb begin
      if (imem_req_i) begin
         src      = SRC_IMEM;
         idx_sel  = imem_idx_i;
         word_sel = imem_wdata_i[WORD_W-1:0];
      end else begin
         src      = SRC_DMEM;
         idx_sel  = dmem_idx_i;
         word_sel = dmem_wdata_i[WORD_W-1:0];
      end
   end

   assign idx_ext = REC_IDX_W'(idx_sel);
   assign rec_o   = {src == SRC_IMEM, idx_ext, word_sel};

endmodule

// File: rtl/memwr_crc_acc.sv
module memwr_crc_acc
   import memwr_crc_pkg::*;
#(
   parameter int unsigned      BUS_DW    = 32,
   parameter int unsigned      IDX_W     = DefIdxW,
   parameter int unsigned      REC_IDX_W = DefRecIdxW,
   parameter int unsigned      MASK_W    = DefMaskW,
   parameter int unsigned      IMEM_WD_W = 39,
   parameter int unsigned      DMEM_WD_W = 32,
   parameter int unsigned      CRC_W     = DefCrcW,
   parameter logic [CRC_W-1:0] POLY      = Crc32ReflPoly
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 imem_host_req_i,
   input  logic [MASK_W-1:0]    imem_host_mask_i,
   input  logic [IDX_W-1:0]     imem_host_idx_i,
   input  logic [IMEM_WD_W-1:0] imem_host_wdata_i,
   input  logic                 dmem_host_req_i,
   input  logic [MASK_W-1:0]    dmem_host_mask_i,
   input  logic [IDX_W-1:0]     dmem_host_idx_i,
   input  logic [DMEM_WD_W-1:0] dmem_host_wdata_i,
   input  logic                 core_imem_acc_i,
   input  logic                 core_dmem_acc_i,
   input  logic                 crc_wr_i,
   input  logic [CRC_W-1:0]     crc_wdata_i,
   output logic [CRC_W-1:0]     crc_o
);

   localparam int unsigned WordW = BUS_DW;
   localparam int unsigned RecW  = 1 + REC_IDX_W + WordW;
   localparam logic [MASK_W-1:0] FullMask = {MASK_W{1'b1}};

   // The record layout and mask width assume a 32-bit bus word
   if (BUS_DW != 32) begin : g_bad_bus_dw
      $error("memwr_crc_acc: BUS_DW must be 32");
   end
   if (MASK_W != BUS_DW / 8) begin : g_bad_mask_w
      $error("memwr_crc_acc: MASK_W must be BUS_DW/8");
   end

   logic             fold_en;
   logic [RecW-1:0]  rec;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_folded;

   memwr_crc_qual #(
      .IDX_W     (IDX_W),
      .REC_IDX_W (REC_IDX_W),
      .WORD_W    (WordW),
      .MASK_W    (MASK_W),
      .IMEM_WD_W (IMEM_WD_W),
      .DMEM_WD_W (DMEM_WD_W)
   ) u_qual (
      .imem_req_i   (imem_host_req_i),
      .imem_mask_i  (imem_host_mask_i),
      .imem_idx_i   (imem_host_idx_i),
      .imem_wdata_i (imem_host_wdata_i),
      .dmem_req_i   (dmem_host_req_i),
      .dmem_mask_i  (dmem_host_mask_i),
      .dmem_idx_i   (dmem_host_idx_i),
      .dmem_wdata_i (dmem_host_wdata_i),
      .core_imem_i  (core_imem_acc_i),
      .core_dmem_i  (core_dmem_acc_i),
      .fold_en_o    (fold_en),
      .rec_o        (rec)
   );

   memwr_crc_fold #(
      .CRC_W (CRC_W),
      .REC_W (RecW),
      .POLY  (POLY)
   ) u_fold (
      .crc_i (crc_q),
      .rec_i (rec),
      .crc_o (crc_folded)
   );

   // Host load outranks a fold (R7)
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         crc_q <= '0;
      end else if (crc_wr_i) begin
         crc_q <= crc_wdata_i;
      end else if (fold_en) begin
         crc_q <= crc_folded;
      end
   end

   assign crc_o = crc_q;

   // R8: synchronous reset clears the register
   a_r8_sync_clear: assert property (@(posedge clk_i)
      !rst_ni |=> crc_o == '0);

   // R6: a host load appears one edge later
   a_r6_host_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      crc_wr_i |=> crc_o == $past(crc_wdata_i));

   // R4: core traffic freezes the sum
   a_r4_core_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!crc_wr_i && (core_imem_acc_i || core_dmem_acc_i)) |=> $stable(crc_o));

   // R3: no full-mask request, no change
   a_r3_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!crc_wr_i &&
       !(imem_host_req_i && imem_host_mask_i == FullMask) &&
       !(dmem_host_req_i && dmem_host_mask_i == FullMask)) |=> $stable(crc_o));

   // R9: idle bus holds the value
   a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!crc_wr_i && !imem_host_req_i && !dmem_host_req_i) |=> $stable(crc_o));

endmodule

// File: tb/memwr_crc_acc_tb.sv
module memwr_crc_acc_tb;

   localparam int unsigned IWD = 39;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            ireq, dreq, ci, cd, hw;
   logic [3:0]      imask, dmask;
   logic [9:0]      iidx, didx;
   logic [IWD-1:0]  idata;
   logic [31:0]     ddata, hwd;
   logic [31:0]     crc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   memwr_crc_acc u_dut (
      .clk_i             (clk),
      .rst_ni            (rst_n),
      .imem_host_req_i   (ireq),
      .imem_host_mask_i  (imask),
      .imem_host_idx_i   (iidx),
      .imem_host_wdata_i (idata),
      .dmem_host_req_i   (dreq),
      .dmem_host_mask_i  (dmask),
      .dmem_host_idx_i   (didx),
      .dmem_host_wdata_i (ddata),
      .core_imem_acc_i   (ci),
      .core_dmem_acc_i   (cd),
      .crc_wr_i          (hw),
      .crc_wdata_i       (hwd),
      .crc_o             (crc)
   );

   // Bit-serial reference: record bit 0 first, reflected polynomial
   function automatic logic [31:0] ref_fold(input logic [31:0] c_in, input logic sel,
                                            input logic [9:0] idx, input logic [31:0] w);
      logic [47:0] r;
      logic [31:0] c;
      logic        fb;
      r = {sel, 5'b00000, idx, w};
      c = c_in;
      for (int i = 0; i < 48; i++) begin
         fb = c[0] ^ r[i];
         c  = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c;
   endfunction

   // kind: 0 hold, 1 fold instruction-store record, 2 fold data-store record, 3 host load
   typedef struct packed {
      logic [3:0]  req;
      logic        hw;
      logic [31:0] hwd;
      logic        ir;
      logic [3:0]  im;
      logic [9:0]  ii;
      logic [31:0] id;
      logic        dr;
      logic [3:0]  dm;
      logic [9:0]  di;
      logic [31:0] dd;
      logic        ci;
      logic        cd;
      logic [1:0]  kind;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{4'd6, 1'b1, 32'hFFFFFFFF, 1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 1'b0, 2'd3}, // R6
      '{4'd2, 1'b0, 32'h0,        1'b1, 4'hF, 10'd3,   32'hA5A55A5A, 1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 1'b0, 2'd1}, // R2
      '{4'd1, 1'b0, 32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 4'hF, 10'h3FF, 32'h12345678, 1'b0, 1'b0, 2'd2}, // R1
      '{4'd3, 1'b0, 32'h0,        1'b1, 4'h7, 10'd4,   32'hDEADBEEF, 1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 1'b0, 2'd0}, // R3
      '{4'd3, 1'b0, 32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 4'hE, 10'd9,   32'h0BADF00D, 1'b0, 1'b0, 2'd0}, // R3
      '{4'd3, 1'b0, 32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 4'h0, 10'd9,   32'h0BADF00D, 1'b0, 1'b0, 2'd0}, // R3
      '{4'd4, 1'b0, 32'h0,        1'b1, 4'hF, 10'd5,   32'hCAFEBABE, 1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 1'b0, 2'd0}, // R4
      '{4'd4, 1'b0, 32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 4'hF, 10'd6,   32'hCAFEBABE, 1'b0, 1'b1, 2'd0}, // R4
      '{4'd4, 1'b0, 32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 4'hF, 10'd7,   32'h00C0FFEE, 1'b1, 1'b0, 2'd0}, // R4
      '{4'd9, 1'b0, 32'h0,        1'b0, 4'hF, 10'd8,   32'h11111111, 1'b0, 4'hF, 10'd8,   32'h22222222, 1'b0, 1'b0, 2'd0}, // R9
      '{4'd7, 1'b1, 32'h5A5A5A5A, 1'b1, 4'hF, 10'd10,  32'h33333333, 1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 1'b0, 2'd3}, // R7
      '{4'd5, 1'b0, 32'h0,        1'b1, 4'hF, 10'd11,  32'h44444444, 1'b1, 4'hF, 10'd12,  32'h55555555, 1'b0, 1'b0, 2'd1}, // R5
      '{4'd5, 1'b0, 32'h0,        1'b1, 4'h3, 10'd13,  32'h66666666, 1'b1, 4'hF, 10'd14,  32'h77777777, 1'b0, 1'b0, 2'd1}, // R5
      '{4'd6, 1'b1, 32'h00000000, 1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 1'b0, 2'd3}, // R6
      '{4'd2, 1'b0, 32'h0,        1'b0, 4'h0, 10'd0,   32'h0,        1'b1, 4'hF, 10'd0,   32'h00000000, 1'b0, 1'b0, 2'd2}, // R2
      '{4'd1, 1'b0, 32'h0,        1'b1, 4'hF, 10'd1,   32'hFFFFFFFF, 1'b0, 4'h0, 10'd0,   32'h0,        1'b0, 1'b0, 2'd1}  // R1
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: crc_o actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ireq = 1'b0; imask = 4'h0; iidx = '0; idata = '0;
      dreq = 1'b0; dmask = 4'h0; didx = '0; ddata = '0;
      ci = 1'b0; cd = 1'b0; hw = 1'b0; hwd = '0;
   endtask

   task automatic apply(input vec_t v);
      hw = v.hw; hwd = v.hwd;
      ireq = v.ir; imask = v.im; iidx = v.ii;
      idata = {7'h55, v.id};   // bits above the word must not matter
      dreq = v.dr; dmask = v.dm; didx = v.di; ddata = v.dd;
      ci = v.ci; cd = v.cd;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] model;
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R8: value after reset
      check(8, crc, 32'h0);
      model = 32'h0;

      // Table walk: drive at a falling edge, result after the next rising edge
      for (int n = 0; n < NV; n++) begin
         apply(TBL[n]);
         case (TBL[n].kind)
            2'd1:    model = ref_fold(model, 1'b1, TBL[n].ii, TBL[n].id);
            2'd2:    model = ref_fold(model, 1'b0, TBL[n].di, TBL[n].dd);
            2'd3:    model = TBL[n].hwd;
            default: model = model;
         endcase
         @(negedge clk);
         check(int'(TBL[n].req), crc, model);
      end

      // R2: back-to-back folds from a non-zero seed, alternating stores
      idle_inputs();
      hw = 1'b1; hwd = 32'h89ABCDEF;
      model = 32'h89ABCDEF;
      @(negedge clk);
      check(6, crc, model);
      hw = 1'b0;
      for (int k = 0; k < 8; k++) begin
         logic [31:0] w;
         logic [9:0]  ix;
         w  = 32'h01020304 * (k + 3);
         ix = 10'(k * 97);
         ireq = k[0]; imask = 4'hF; iidx = ix; idata = {7'h7F, w};
         dreq = ~k[0]; dmask = 4'hF; didx = ix; ddata = w;
         model = ref_fold(model, k[0], ix, w);
         @(negedge clk);
         check(2, crc, model);
      end

      // R9: several idle cycles keep the value
      idle_inputs();
      repeat (3) @(negedge clk);
      check(9, crc, model);

      // R8: reset overrides a pending load and a qualifying write
      hw = 1'b1; hwd = 32'hFEEDFACE;
      ireq = 1'b1; imask = 4'hF; iidx = 10'd2; idata = '1;
      rst_n = 1'b0;
      @(negedge clk);
      check(8, crc, 32'h0);
      idle_inputs();
      rst_n = 1'b1;
      @(negedge clk);
      check(8, crc, 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule